// File: doc/BRIEF.md
# Multi-Channel Fractional Tick Divider

This block takes one base tick strobe, nominally 500 Hz, and derives several independent event rates from it. Every channel holds a 3-bit rate code, an 8-bit main down-counter and a 2-bit stretch counter. The main counter gives whole submultiples of the base rate. The stretch counter makes every Nth period one base tick longer, so rates that do not divide the base evenly still come out right on average. A 60 Hz channel, for example, runs in periods of 8, 8 and 9 ticks, which is three events in every 25 base ticks.

When a channel's main counter runs out, the channel reloads it and raises a one-cycle request on its own output. Software chooses a channel's rate through a write port that carries a channel index, a code and a strobe. Each channel's code and counters can be read back through a combinational read port. A resync strobe reloads every channel's counters from the code that channel currently holds. The two highest channels are always running: they refuse the off code, and the top channel cannot be reprogrammed at all. Any write the block rejects sets an error pulse.

Top module: `tick_divider`

## Requirements
- R1: After reset, channels 0 and 1 hold code 0 (off) and channels 2 and 3 hold code 1 (500 Hz). Every channel's counters hold the reload values of its code. All request outputs and the error output are low.
- R2: A nonzero main counter decreases by exactly one on each cycle with the tick input high, provided no write to that channel and no resync occur in that cycle. Without a tick, the counters keep their values.
- R3: A channel whose main counter is zero never expires and never raises its request, whatever the tick input does.
- R4: Each code sets a reload and a stretch value: 0 gives 0/0, 1 gives 1/0, 2 gives 10/0, 3 gives 8/3, 4 gives 5/0, and 5 gives 250/0.
- R5: A tick that finds the main counter at 1 reloads the counter and drives that channel's request bit high for exactly the next cycle.
- R6: On expiry, a nonzero stretch counter decreases by one. If it reaches zero, the reloaded main count is one larger and the stretch counter reloads. Under code 3, expiries fall on base ticks 8, 16, 24, 33, 41, 49 and 58 after the write.
- R7: An accepted write loads the code and both counters from that code in the next cycle. It overrides a tick in the same cycle for that channel, and no request is raised.
- R8: A write is rejected in any of these cases: it carries code 6 or 7, it carries code 0 to channel 2 or 3, or it targets channel 3. A rejected write changes no state and sets the error output high in the following cycle.
- R9: The resync input reloads every channel's counters from its current code and overrides a same-cycle tick. A same-cycle accepted write still takes effect on its own channel.
- R10: All channels update in parallel, so one tick can raise several request bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base rate strobe, one cycle per base tick |
| resync | input | 1 | Reload all counters from current codes |
| wr_en | input | 1 | Rate write strobe |
| wr_ch | input | 2 | Channel index for a write |
| wr_code | input | 3 | Rate code for a write |
| rd_ch | input | 2 | Channel index for read-back |
| rd_code | output | 3 | Code of the selected channel |
| rd_cnt | output | 8 | Main counter of the selected channel |
| rd_xtra | output | 2 | Stretch counter of the selected channel |
| irq | output | 4 | One-cycle request per channel |
| wr_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
In the same cycle, a channel's expiry on a tick can collide with a write to that channel or with a resync. To provoke this, the bench runs a channel down to a count of 1 and then raises the tick together with a write, or raises the tick together with resync. It judges the result by whether a request appears in the following cycle and by the count read back. A write's reload must win and no request may appear. Resync must also win, which is seen on the channel that would otherwise fire on every tick.

// File: rtl/tickdiv_pkg.sv
package tickdiv_pkg;

    localparam int CODE_W = 3;
    localparam int CNT_W  = 8;
    localparam int XTRA_W = 2;

    typedef enum logic [CODE_W-1:0] {
        RATE_OFF  = 3'd0,
        RATE_500  = 3'd1,
        RATE_50   = 3'd2,
        RATE_60   = 3'd3,
        RATE_100  = 3'd4,
        RATE_2    = 3'd5
    } rate_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [XTRA_W-1:0] xtra;
    } ch_state_t;

    typedef struct packed {
        logic [CNT_W-1:0]  reload;
        logic [XTRA_W-1:0] xreload;
    } rate_t;

    function automatic rate_t rate_lookup(logic [CODE_W-1:0] code);
        rate_t r;
        r = '0;
        case (code)
            RATE_500: r.reload = 8'd1;
            RATE_50:  r.reload = 8'd10;
            RATE_60:  begin r.reload = 8'd8; r.xreload = 2'd3; end
            RATE_100: r.reload = 8'd5;
            RATE_2:   r.reload = 8'd250;
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic logic code_defined(logic [CODE_W-1:0] code);
        return code <= CODE_W'(RATE_2);
    endfunction

    function automatic logic [CODE_W-1:0] default_code(int ch, int first_live);
        return (ch >= first_live) ? CODE_W'(RATE_500) : CODE_W'(RATE_OFF);
    endfunction

    function automatic ch_state_t fresh_state(logic [CODE_W-1:0] code);
        rate_t     r;
        ch_state_t s;
        r      = rate_lookup(code);
        s.cnt  = r.reload;
        s.xtra = r.xreload;
        return s;
    endfunction

endpackage

// File: rtl/tickdiv_wr_check.sv
module tickdiv_wr_check
    import tickdiv_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int NOOFF_FIRST = 2,
    parameter int LOCKED_CH   = 3,
    parameter int CH_W        = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CH_W-1:0]      wr_ch,
    input  logic [CODE_W-1:0]    wr_code,
    output logic [NUM_CH-1:0]    load,
    output logic                 err
);

    logic in_range;
    logic locked;
    logic guarded;
    logic legal;

    always_comb begin
        in_range = 1'b0;
        locked   = 1'b0;
        guarded  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_ch == CH_W'(i)) begin
                in_range = 1'b1;
                if (i == LOCKED_CH)   locked  = 1'b1;
                if (i >= NOOFF_FIRST) guarded = 1'b1;
            end
        end
        legal = in_range && !locked && code_defined(wr_code)
                && !(guarded && (wr_code == CODE_W'(RATE_OFF)));
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            load[i] = wr_en && legal && (wr_ch == CH_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= wr_en && !legal;
    end

endmodule

// File: rtl/tickdiv_channel.sv
module tickdiv_channel
    import tickdiv_pkg::*;
#(
    parameter logic [2:0] RST_CODE = 3'd0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               resync,
    input  logic               load,
    input  logic [CODE_W-1:0]  load_code,
    output logic [CODE_W-1:0]  code,
    output ch_state_t          st,
    output logic               irq
);

    rate_t cur;
    assign cur = rate_lookup(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= RST_CODE;
            st   <= fresh_state(RST_CODE);
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                code <= load_code;
                st   <= fresh_state(load_code);
            end else if (resync) begin
                st <= fresh_state(code);
            end else if (tick && (st.cnt != '0)) begin
                if (st.cnt == CNT_W'(1)) begin
                    irq <= 1'b1;
                    if (st.xtra == XTRA_W'(1)) begin
                        st.cnt  <= cur.reload + CNT_W'(1);
                        st.xtra <= cur.xreload;
                    end else if (st.xtra != '0) begin
                        st.cnt  <= cur.reload;
                        st.xtra <= st.xtra - XTRA_W'(1);
                    end else begin
                        st.cnt  <= cur.reload;
                    end
                end else begin
                    st.cnt <= st.cnt - CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tickdiv_readmux.sv
module tickdiv_readmux
    import tickdiv_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [CH_W-1:0]                 sel,
    input  logic [NUM_CH-1:0][CODE_W-1:0]   codes,
    input  ch_state_t [NUM_CH-1:0]          states,
    output logic [CODE_W-1:0]               code_o,
    output logic [CNT_W-1:0]                cnt_o,
    output logic [XTRA_W-1:0]               xtra_o
);

    always_comb begin
        code_o = '0;
        cnt_o  = '0;
        xtra_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel == CH_W'(i)) begin
                code_o = codes[i];
                cnt_o  = states[i].cnt;
                xtra_o = states[i].xtra;
            end
        end
    end

endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import tickdiv_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int NOOFF_FIRST = 2,
    parameter int LOCKED_CH   = NUM_CH - 1,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                resync,
    input  logic                wr_en,
    input  logic [CH_W-1:0]     wr_ch,
    input  logic [CODE_W-1:0]   wr_code,
    input  logic [CH_W-1:0]     rd_ch,
    output logic [CODE_W-1:0]   rd_code,
    output logic [CNT_W-1:0]    rd_cnt,
    output logic [XTRA_W-1:0]   rd_xtra,
    output logic [NUM_CH-1:0]   irq,
    output logic                wr_err
);

    logic [NUM_CH-1:0]             load_v;
    logic [NUM_CH-1:0][CODE_W-1:0] codes_q;
    ch_state_t [NUM_CH-1:0]        states_q;

    tickdiv_wr_check #(
        .NUM_CH      (NUM_CH),
        .NOOFF_FIRST (NOOFF_FIRST),
        .LOCKED_CH   (LOCKED_CH),
        .CH_W        (CH_W)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_code (wr_code),
        .load    (load_v),
        .err     (wr_err)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tickdiv_channel #(
            .RST_CODE (default_code(g, NOOFF_FIRST))
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .resync    (resync),
            .load      (load_v[g]),
            .load_code (wr_code),
            .code      (codes_q[g]),
            .st        (states_q[g]),
            .irq       (irq[g])
        );
    end

    tickdiv_readmux #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_rd (
        .sel    (rd_ch),
        .codes  (codes_q),
        .states (states_q),
        .code_o (rd_code),
        .cnt_o  (rd_cnt),
        .xtra_o (rd_xtra)
    );

endmodule

// File: rtl/tickdiv_chk.sv
module tickdiv_chk
    import tickdiv_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int NOOFF_FIRST = 2,
    parameter int LOCKED_CH   = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            tick,
    input logic                            resync,
    input logic [NUM_CH-1:0]               irq,
    input logic                            wr_err,
    input logic [NUM_CH-1:0]               load,
    input logic [NUM_CH-1:0][CODE_W-1:0]   codes,
    input ch_state_t [NUM_CH-1:0]          states
);

    // R8
    locked_code_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(codes[LOCKED_CH]));

    // R8
    reject_keeps_codes_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $stable(codes));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_p
        // R3
        idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
            (tick && states[g].cnt == '0 && !load[g] && !resync) |=> !irq[g]);

        // R5
        irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> $past(tick));

        // R5
        reload_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> (states[g].cnt != '0));

        // R2
        count_step_chk: assert property (@(posedge clk) disable iff (rst)
            (tick && states[g].cnt > CNT_W'(1) && !load[g] && !resync)
            |=> (states[g].cnt == $past(states[g].cnt) - CNT_W'(1)));

        // R2
        hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (!tick && !load[g] && !resync) |=> $stable(states[g]));

        if (g >= NOOFF_FIRST) begin : g_live
            // R8
            never_off_chk: assert property (@(posedge clk) disable iff (rst)
                codes[g] != CODE_W'(RATE_OFF));
        end
    end

endmodule

bind tick_divider tickdiv_chk #(
    .NUM_CH      (NUM_CH),
    .NOOFF_FIRST (NOOFF_FIRST),
    .LOCKED_CH   (LOCKED_CH)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .resync (resync),
    .irq    (irq),
    .wr_err (wr_err),
    .load   (load_v),
    .codes  (codes_q),
    .states (states_q)
);

// File: tb/test_tick_divider.sv
module test_tick_divider;
    import tickdiv_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       resync = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_ch = '0;
    logic [2:0] wr_code = '0;
    logic [1:0] rd_ch = '0;
    logic [2:0] rd_code;
    logic [7:0] rd_cnt;
    logic [1:0] rd_xtra;
    logic [3:0] irq;
    logic       wr_err;

    int checks = 0;
    int fails  = 0;

    tick_divider i_tick_divider (
        .clk(clk), .rst(rst), .tick(tick), .resync(resync),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
        .rd_ch(rd_ch), .rd_code(rd_code), .rd_cnt(rd_cnt), .rd_xtra(rd_xtra),
        .irq(irq), .wr_err(wr_err)
    );

    always #5 clk = ~clk;

    function automatic int exp_reload(int code);
        case (code)
            1: return 1;
            2: return 10;
            3: return 8;
            4: return 5;
            5: return 250;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_xtra(int code);
        return (code == 3) ? 3 : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1'b1; cyc(); tick = 1'b0;
    endtask

    task automatic do_write(input int ch, input int code);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_code = 3'(code);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic read_ch(input int ch, output int code, output int cnt, output int xtra);
        rd_ch = 2'(ch);
        #1;
        code = int'(rd_code); cnt = int'(rd_cnt); xtra = int'(rd_xtra);
    endtask

    task automatic t_reset();
        int c, n, x;
        for (int ch = 0; ch < 4; ch++) begin
            read_ch(ch, c, n, x);
            chk("R1", $sformatf("code ch%0d", ch), c, (ch >= 2) ? 1 : 0);
            chk("R1", $sformatf("cnt ch%0d", ch), n, (ch >= 2) ? 1 : 0);
            chk("R1", $sformatf("xtra ch%0d", ch), x, 0);
        end
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "err", int'(wr_err), 0);
    endtask

    task automatic t_parallel_and_off();
        for (int k = 0; k < 3; k++) begin
            do_tick();
            // R3 off channels silent, R10 two live channels together
            chk("R3", "irq off ch0/1", int'(irq[1:0]), 0);
            chk("R10", "irq ch2/3 together", int'(irq[3:2]), 3);
        end
        cyc();
        chk("R5", "irq drops without tick", int'(irq), 0);
    endtask

    task automatic t_table();
        int c, n, x;
        for (int code = 5; code >= 0; code--) begin
            do_write(0, code);
            read_ch(0, c, n, x);
            chk("R4", $sformatf("code %0d stored", code), c, code);
            chk("R4", $sformatf("reload of code %0d", code), n, exp_reload(code));
            chk("R7", $sformatf("stretch of code %0d", code), x, exp_xtra(code));
        end
    endtask

    task automatic t_decrement();
        int c, n, x;
        do_write(1, 2);
        repeat (3) do_tick();
        read_ch(1, c, n, x);
        chk("R2", "cnt after 3 ticks", n, 7);
        repeat (3) cyc();
        read_ch(1, c, n, x);
        chk("R2", "cnt holds without tick", n, 7);
    endtask

    task automatic t_expire();
        int c, n, x;
        do_write(1, 4);
        for (int k = 1; k <= 4; k++) begin
            do_tick();
            chk("R5", $sformatf("no irq at tick %0d", k), int'(irq[1]), 0);
        end
        do_tick();
        chk("R5", "irq at 5th tick", int'(irq[1]), 1);
        read_ch(1, c, n, x);
        chk("R5", "reload after expiry", n, 5);
        cyc();
        chk("R5", "irq one cycle wide", int'(irq[1]), 0);
    endtask

    task automatic t_sixty();
        int c, n, x;
        int hits;
        bit expect_hit;
        do_write(0, 3);
        hits = 0;
        for (int t = 1; t <= 58; t++) begin
            do_tick();
            expect_hit = (t == 8 || t == 16 || t == 24 || t == 33 ||
                          t == 41 || t == 49 || t == 58);
            chk("R6", $sformatf("60Hz irq at tick %0d", t), int'(irq[0]), int'(expect_hit));
            if (irq[0]) hits++;
            if (t == 8) begin
                read_ch(0, c, n, x);
                chk("R6", "stretch after first expiry", x, 2);
            end
            if (t == 24) begin
                read_ch(0, c, n, x);
                chk("R6", "long period loaded", n, 9);
                chk("R6", "stretch reloaded", x, 3);
            end
        end
        chk("R6", "expiries in 58 ticks", hits, 7);
    endtask

    task automatic t_reject();
        int c, n, x;
        int c0, n0, x0;
        read_ch(0, c0, n0, x0);
        do_write(0, 6);
        chk("R8", "err on code 6", int'(wr_err), 1);
        read_ch(0, c, n, x);
        chk("R8", "ch0 code kept", c, c0);
        chk("R8", "ch0 cnt kept", n, n0);
        do_write(1, 7);
        chk("R8", "err on code 7", int'(wr_err), 1);
        do_write(2, 0);
        chk("R8", "err on off to ch2", int'(wr_err), 1);
        read_ch(2, c, n, x);
        chk("R8", "ch2 still 500Hz", c, 1);
        do_write(3, 2);
        chk("R8", "err on locked ch3", int'(wr_err), 1);
        read_ch(3, c, n, x);
        chk("R8", "ch3 code kept", c, 1);
        chk("R8", "ch3 cnt kept", n, 1);
        do_write(2, 4);
        chk("R8", "no err on legal write", int'(wr_err), 0);
        read_ch(2, c, n, x);
        chk("R7", "ch2 accepts code 4", c, 4);
        cyc();
        chk("R8", "err one cycle wide", int'(wr_err), 0);
    endtask

    task automatic t_collide();
        int c, n, x;
        do_write(1, 4);
        repeat (4) do_tick();
        read_ch(1, c, n, x);
        chk("R7", "ch1 at last count", n, 1);
        tick = 1'b1; wr_en = 1'b1; wr_ch = 2'd1; wr_code = 3'd2;
        cyc();
        tick = 1'b0; wr_en = 1'b0;
        chk("R7", "write beats expiry: no irq", int'(irq[1]), 0);
        read_ch(1, c, n, x);
        chk("R7", "write beats expiry: cnt", n, 10);
    endtask

    task automatic t_resync();
        int c, n, x;
        do_write(2, 1);
        repeat (3) do_tick();
        read_ch(1, c, n, x);
        chk("R2", "ch1 after 3 ticks", n, 7);
        tick = 1'b1; resync = 1'b1;
        wr_en = 1'b1; wr_ch = 2'd0; wr_code = 3'd4;
        cyc();
        tick = 1'b0; resync = 1'b0; wr_en = 1'b0;
        chk("R9", "resync beats tick: no irq", int'(irq), 0);
        read_ch(1, c, n, x);
        chk("R9", "ch1 reloaded", n, 10);
        read_ch(0, c, n, x);
        chk("R9", "write wins on ch0 code", c, 4);
        chk("R9", "write wins on ch0 cnt", n, 5);
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_parallel_and_off();
        t_table();
        t_decrement();
        t_expire();
        t_sixty();
        t_reject();
        t_collide();
        t_resync();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule